// File: doc/BRIEF.md
# Byte-Lane Parity Unit for a Multiplexed Address/Data Bus

This block sits beside a 32-bit multiplexed address/data bus and handles parity at two levels at once. One level is the usual whole-word parity bit, which covers the data and the command/byte-enable lines. The other level is four byte-lane parity lines, one for each byte of the data. The transaction role (bus master or target, read or write) and the phase qualifiers decide on every clock whether the word on the bus is arriving or leaving.

For leaving words, the block works out both parity levels and drives them one clock later, together with an output enable. For arriving words, it compares the parity lines seen one clock later with the values computed from the captured word. Lane mismatches and word-parity mismatches collect in sticky flags, which stay set until a clear strobe. Checking of the byte lanes is always on. When the direction changes, the clock after the phase is a bus turnaround, and the block neither drives nor checks in that clock.

Top module: `lane_parity_unit`

## Requirements
- R1: When a leaving word is captured, `par_oe_o` is 1 in the next clock and `par_o` is then the XOR of all 32 `ad_i` bits and all 4 `cbe_i` bits of that word (even parity).
- R2: In the same clock, `bpar_o[k]` is the XOR of `ad_i[8k+7:8k]` of the captured word, for each lane k in 0..3.
- R3: The direction is decided as follows. In an address phase (`addr_phase_i`=1), the word is leaving when `is_master_i`=1 and arriving when it is 0. In a data phase, the word is arriving for master-read (`is_master_i`=1, `is_read_i`=1) and for target-write (0, 0), and leaving for master-write (1, 0) and target-read (0, 1).
- R4: When an arriving word is captured, each lane k whose `bpar_i[k]` in the next clock differs from the even parity of that lane sets `lane_err_o[k]` two clocks after the phase. Nothing can disable this check.
- R5: The word-parity check runs on the same phase. A mismatch between `par_i` and the parity of the captured data plus byte enables sets `par_err_o` without touching `lane_err_o`, and a lane mismatch does not touch `par_err_o`.
- R6: A clock is a phase only when `addr_phase_i`=1 or when `irdy_i` and `trdy_i` are both 1. Idle clocks and wait states lead to no drive and no check.
- R7: The clock after a phase is a turnaround when the direction decoded in that clock differs from the direction of the phase. In a turnaround clock the block drives nothing and checks nothing. Whenever `par_oe_o`=0, `par_o` and `bpar_o` are 0.
- R8: The error flags hold their value until `err_clr_i`=1. The clear takes effect one clock later. A mismatch found in the same clock as the clear survives the clear.
- R9: During reset, `par_oe_o`, `lane_err_o` and `par_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Address/data value seen on the bus |
| cbe_i | input | 4 | Command/byte-enable value seen on the bus |
| addr_phase_i | input | 1 | This clock is an address phase |
| irdy_i | input | 1 | Initiator ready, active high |
| trdy_i | input | 1 | Target ready, active high |
| is_master_i | input | 1 | 1 when this agent is the bus master |
| is_read_i | input | 1 | 1 for a read transaction |
| par_i | input | 1 | Word parity line as received |
| bpar_i | input | 4 | Byte-lane parity lines as received |
| err_clr_i | input | 1 | Clears the sticky error flags |
| par_o | output | 1 | Generated word parity |
| bpar_o | output | 4 | Generated byte-lane parity |
| par_oe_o | output | 1 | Enables driving of `par_o` and `bpar_o` |
| lane_err_o | output | 4 | Sticky per-lane mismatch flags |
| par_err_o | output | 1 | Sticky word-parity mismatch flag |

## Verification
Generated parity and its enable are due in the clock after the phase. An error flag is due one clock later still, because the parity lines for an arriving word come in the clock after the word and are then registered. A clear shows one clock after the strobe. The driver task stamps every expected item with the clock number in which it falls due. The monitor samples at the falling edge and takes items off the queue only in that clock, so any result that comes early or late fails the check, even when its value is right.

// File: rtl/lp_pkg.sv
package lp_pkg;
    // Direction of the word on the bus in a given clock.
    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } lp_dir_e;
endpackage

// File: rtl/lp_dir_decode.sv
module lp_dir_decode
    import lp_pkg::*;
(
    input  logic    addr_phase_i,
    input  logic    irdy_i,
    input  logic    trdy_i,
    input  logic    is_master_i,
    input  logic    is_read_i,
    output logic    qual_o,
    output lp_dir_e dir_o
);
    always_comb begin
        qual_o = addr_phase_i | (irdy_i & trdy_i);
        if (addr_phase_i) begin
            // the master always owns the bus during the address
            dir_o = is_master_i ? DIR_OUT : DIR_IN;
        end else begin
            // master-write and target-read leave, the other two arrive
            dir_o = (is_master_i ^ is_read_i) ? DIR_OUT : DIR_IN;
        end
    end
endmodule

// File: rtl/lp_lane_parity.sv
module lp_lane_parity #(
    parameter  int DATA_W = 32,
    parameter  int LANE_W = 8,
    localparam int LANES  = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [LANES-1:0]  par_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par_o[g] = ^data_i[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lp_err_accum.sv
module lp_err_accum #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             check_i,
    input  logic [LANES-1:0] lane_mis_i,
    input  logic             par_mis_i,
    input  logic             clr_i,
    output logic [LANES-1:0] lane_err_o,
    output logic             par_err_o
);
    typedef struct packed {
        logic [LANES-1:0] lane;
        logic             par;
    } err_t;

    err_t err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (clr_i) begin
            err_d = '0;
        end
        // a fresh mismatch is merged after the clear so it is never lost
        if (check_i) begin
            err_d.lane = err_d.lane | lane_mis_i;
            err_d.par  = err_d.par | par_mis_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign lane_err_o = err_q.lane;
    assign par_err_o  = err_q.par;
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
    import lp_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int LANE_W = 8,
    localparam int LANES  = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [LANES-1:0]  cbe_i,
    input  logic              addr_phase_i,
    input  logic              irdy_i,
    input  logic              trdy_i,
    input  logic              is_master_i,
    input  logic              is_read_i,
    input  logic              par_i,
    input  logic [LANES-1:0]  bpar_i,
    input  logic              err_clr_i,
    output logic              par_o,
    output logic [LANES-1:0]  bpar_o,
    output logic              par_oe_o,
    output logic [LANES-1:0]  lane_err_o,
    output logic              par_err_o
);
    // The captured phase: whether it was a phase, its direction, and both parities.
    typedef struct packed {
        logic             vld;
        lp_dir_e          dir;
        logic             par;
        logic [LANES-1:0] bpar;
    } cap_t;

    cap_t             cap_d, cap_q;
    logic             qual;
    lp_dir_e          dir_now;
    logic [LANES-1:0] bpar_calc;
    logic             turn;
    logic             drive;
    logic             check;
    logic [LANES-1:0] lane_mis;
    logic             par_mis;

    lp_dir_decode u_dir (
        .addr_phase_i (addr_phase_i),
        .irdy_i       (irdy_i),
        .trdy_i       (trdy_i),
        .is_master_i  (is_master_i),
        .is_read_i    (is_read_i),
        .qual_o       (qual),
        .dir_o        (dir_now)
    );

    lp_lane_parity #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_lanes (
        .data_i (ad_i),
        .par_o  (bpar_calc)
    );

    always_comb begin
        cap_d.vld  = qual;
        cap_d.dir  = dir_now;
        cap_d.bpar = bpar_calc;
        // the word parity is the lane parities folded together, plus the byte enables
        cap_d.par  = (^bpar_calc) ^ (^cbe_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    always_comb begin
        turn     = cap_q.vld && (cap_q.dir != dir_now);
        drive    = cap_q.vld && (cap_q.dir == DIR_OUT) && !turn;
        check    = cap_q.vld && (cap_q.dir == DIR_IN) && !turn;
        lane_mis = bpar_i ^ cap_q.bpar;
        par_mis  = par_i ^ cap_q.par;
        par_oe_o = drive;
        par_o    = drive ? cap_q.par : 1'b0;
        bpar_o   = drive ? cap_q.bpar : '0;
    end

    lp_err_accum #(
        .LANES (LANES)
    ) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .check_i    (check),
        .lane_mis_i (lane_mis),
        .par_mis_i  (par_mis),
        .clr_i      (err_clr_i),
        .lane_err_o (lane_err_o),
        .par_err_o  (par_err_o)
    );
endmodule

// File: rtl/lp_checker.sv
module lp_checker #(
    parameter  int DATA_W = 32,
    parameter  int LANE_W = 8,
    localparam int LANES  = DATA_W / LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] ad_i,
    input logic [LANES-1:0]  cbe_i,
    input logic              addr_phase_i,
    input logic              irdy_i,
    input logic              trdy_i,
    input logic              err_clr_i,
    input logic              par_o,
    input logic [LANES-1:0]  bpar_o,
    input logic              par_oe_o,
    input logic [LANES-1:0]  lane_err_o,
    input logic              par_err_o
);
    function automatic logic [LANES-1:0] lane_par(input logic [DATA_W-1:0] d);
        logic [LANES-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[i] = ^d[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

    // R6
    oe_needs_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe_o |-> $past(addr_phase_i | (irdy_i & trdy_i)));

    // R1
    par_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe_o |-> (par_o == ((^$past(ad_i)) ^ (^$past(cbe_i)))));

    // R2
    bpar_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe_o |-> (bpar_o == lane_par($past(ad_i))));

    // R7
    quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_oe_o |-> (!par_o && (bpar_o == '0)));

    // R8
    lane_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr_i |=> ((lane_err_o & $past(lane_err_o)) == $past(lane_err_o)));

    // R8
    par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_o && !err_clr_i) |=> par_err_o);

    // R4
    err_from_arriving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(lane_err_o & ~$past(lane_err_o))) || $rose(par_err_o)) |-> $past(!par_oe_o));
endmodule

bind lane_parity_unit lp_checker #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ad_i         (ad_i),
    .cbe_i        (cbe_i),
    .addr_phase_i (addr_phase_i),
    .irdy_i       (irdy_i),
    .trdy_i       (trdy_i),
    .err_clr_i    (err_clr_i),
    .par_o        (par_o),
    .bpar_o       (bpar_o),
    .par_oe_o     (par_oe_o),
    .lane_err_o   (lane_err_o),
    .par_err_o    (par_err_o)
);

// File: tb/lane_parity_unit_tb_top.sv
module lane_parity_unit_tb_top;
    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    // kinds of scoreboard items
    localparam int K_OE   = 0;
    localparam int K_PAR  = 1;
    localparam int K_BPAR = 2;
    localparam int K_LERR = 3;
    localparam int K_PERR = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] ad_i = '0;
    logic [LANES-1:0]  cbe_i = '0;
    logic              addr_phase_i = 1'b0;
    logic              irdy_i = 1'b0;
    logic              trdy_i = 1'b0;
    logic              is_master_i = 1'b0;
    logic              is_read_i = 1'b0;
    logic              par_i = 1'b0;
    logic [LANES-1:0]  bpar_i = '0;
    logic              err_clr_i = 1'b0;
    logic              par_o;
    logic [LANES-1:0]  bpar_o;
    logic              par_oe_o;
    logic [LANES-1:0]  lane_err_o;
    logic              par_err_o;

    always #4 clk = ~clk;

    lane_parity_unit #(.DATA_W(DATA_W), .LANE_W(LANE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i),
        .addr_phase_i(addr_phase_i), .irdy_i(irdy_i), .trdy_i(trdy_i),
        .is_master_i(is_master_i), .is_read_i(is_read_i),
        .par_i(par_i), .bpar_i(bpar_i), .err_clr_i(err_clr_i),
        .par_o(par_o), .bpar_o(bpar_o), .par_oe_o(par_oe_o),
        .lane_err_o(lane_err_o), .par_err_o(par_err_o)
    );

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int               due;
        int               kind;
        logic [LANES-1:0] val;
        string            req;
    } item_t;
    item_t sb_q[$];

    function automatic logic [LANES-1:0] lanes_of(input logic [DATA_W-1:0] d);
        logic [LANES-1:0] r;
        for (int i = 0; i < LANES; i++) r[i] = ^d[i*LANE_W +: LANE_W];
        return r;
    endfunction

    function automatic logic word_of(input logic [DATA_W-1:0] d, input logic [LANES-1:0] c);
        return (^d) ^ (^c);
    endfunction

    function automatic logic [LANES-1:0] observe(input int kind);
        case (kind)
            K_OE:    return {{(LANES-1){1'b0}}, par_oe_o};
            K_PAR:   return {{(LANES-1){1'b0}}, par_o};
            K_BPAR:  return bpar_o;
            K_LERR:  return lane_err_o;
            default: return {{(LANES-1){1'b0}}, par_err_o};
        endcase
    endfunction

    task automatic expect_at(input int due, input int kind, input logic [LANES-1:0] val, input string req);
        item_t it;
        it.due = due; it.kind = kind; it.val = val; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic direct_check(input int kind, input logic [LANES-1:0] exp, input string req);
        logic [LANES-1:0] act;
        act = observe(kind);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s kind=%0d actual=%h expected=%h", req, kind, act, exp);
        end
    endtask

    // Drive one clock of bus activity; sampled at the next rising edge.
    task automatic step(input logic [DATA_W-1:0] ad, input logic [LANES-1:0] cbe,
                        input logic ap, input logic ir, input logic tr,
                        input logic m, input logic rd,
                        input logic p, input logic [LANES-1:0] bp, input logic clr);
        @(posedge clk);
        #1;
        ad_i = ad; cbe_i = cbe; addr_phase_i = ap; irdy_i = ir; trdy_i = tr;
        is_master_i = m; is_read_i = rd; par_i = p; bpar_i = bp; err_clr_i = clr;
    endtask

    // A leaving word: drive enable and both parity levels one clock later.
    task automatic out_word(input logic [DATA_W-1:0] ad, input logic [LANES-1:0] cbe,
                            input logic ap, input logic m, input logic rd, input string req);
        step(ad, cbe, ap, !ap, !ap, m, rd, 1'b0, '0, 1'b0);
        expect_at(cyc + 1, K_OE, 4'b0001, req);
        expect_at(cyc + 1, K_PAR, {3'b000, word_of(ad, cbe)}, "R1");
        expect_at(cyc + 1, K_BPAR, lanes_of(ad), "R2");
    endtask

    // Monitor: compares scoreboard items in the clock they fall due.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                item_t it;
                logic [LANES-1:0] act;
                it = sb_q.pop_front();
                act = observe(it.kind);
                checks++;
                if (it.due != cyc || act !== it.val) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h due=%0d now=%0d",
                             it.req, it.kind, act, it.val, it.due, cyc);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        direct_check(K_OE, 4'b0000, "R9");
        direct_check(K_LERR, 4'b0000, "R9");
        direct_check(K_PERR, 4'b0000, "R9");
        @(posedge clk); #1; rst_n = 1'b1;

        // R1 R2 R3: back-to-back master-write data phases leave
        out_word(32'hA5C3_0F81, 4'b0000, 1'b0, 1'b1, 1'b0, "R3");
        out_word(32'hFFFF_FFFF, 4'b1011, 1'b0, 1'b1, 1'b0, "R3");
        out_word(32'h0102_0408, 4'b0110, 1'b0, 1'b1, 1'b0, "R3");
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
        expect_at(cyc + 1, K_OE, 4'b0000, "R6");
        expect_at(cyc + 1, K_LERR, 4'b0000, "R4");

        // R3: target-read data phase leaves
        out_word(32'h7E00_13C4, 4'b1110, 1'b0, 1'b0, 1'b1, "R3");
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0);

        // R3: master address phase leaves
        out_word(32'h8000_0040, 4'b0111, 1'b1, 1'b1, 1'b0, "R3");
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);

        // R4: master read, lanes 1 and 3 wrong, word parity right
        w = 32'h3C5A_9612;
        step(w, 4'b0001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0);
        expect_at(cyc + 1, K_OE, 4'b0000, "R3");
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, word_of(w, 4'b0001), lanes_of(w) ^ 4'b1010, 1'b0);
        expect_at(cyc + 1, K_LERR, 4'b1010, "R4");
        expect_at(cyc + 1, K_PERR, 4'b0000, "R5");

        // R8: flags hold across idle clocks with junk parity lines
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1111, 1'b0);
        expect_at(cyc + 1, K_LERR, 4'b1010, "R8");
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0101, 1'b0);
        expect_at(cyc + 1, K_LERR, 4'b1010, "R8");
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b1);
        expect_at(cyc + 1, K_LERR, 4'b0000, "R8");

        // R5: target write, word parity wrong, lanes right
        w = 32'hDEAD_BEEF;
        step(w, 4'b1100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, !word_of(w, 4'b1100), lanes_of(w), 1'b0);
        expect_at(cyc + 1, K_PERR, 4'b0001, "R5");
        expect_at(cyc + 1, K_LERR, 4'b0000, "R5");

        // R8: clear in the same clock as a new lane-0 mismatch
        w = 32'h0000_00FE;
        step(w, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0);
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, word_of(w, 4'b0000), lanes_of(w) ^ 4'b0001, 1'b1);
        expect_at(cyc + 1, K_PERR, 4'b0000, "R8");
        expect_at(cyc + 1, K_LERR, 4'b0001, "R8");
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b1);

        // R6: wait state (target not ready) is ignored
        w = 32'h1234_5678;
        step(w, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
        expect_at(cyc + 1, K_OE, 4'b0000, "R6");
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, !word_of(w, 4'b0000), ~lanes_of(w), 1'b0);
        expect_at(cyc + 1, K_LERR, 4'b0000, "R6");
        expect_at(cyc + 1, K_PERR, 4'b0000, "R6");

        // R3: target address phase arrives, lane 2 wrong
        w = 32'h4000_1000;
        step(w, 4'b0110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        expect_at(cyc + 1, K_OE, 4'b0000, "R3");
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, word_of(w, 4'b0110), lanes_of(w) ^ 4'b0100, 1'b0);
        expect_at(cyc + 1, K_LERR, 4'b0100, "R3");
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
        expect_at(cyc + 1, K_LERR, 4'b0000, "R8");

        // R7: master address then read turnaround: nothing driven
        step(32'h9000_0000, 4'b0110, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
        expect_at(cyc, K_OE, 4'b0000, "R7");
        expect_at(cyc, K_BPAR, 4'b0000, "R7");

        // R7: target address then read turnaround: bad lines not checked
        w = 32'h55AA_33CC;
        step(w, 4'b0110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, !word_of(w, 4'b0110), ~lanes_of(w), 1'b0);
        expect_at(cyc, K_OE, 4'b0000, "R7");
        expect_at(cyc + 1, K_LERR, 4'b0000, "R7");
        expect_at(cyc + 1, K_PERR, 4'b0000, "R7");

        repeat (4) @(posedge clk);
        @(negedge clk);
        #1;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R1 scoreboard left actual=%0d expected=0", sb_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule